// File: doc/BRIEF.md
# USB Device Interrupt Enable and Flag Registers

This block is the interrupt unit of a USB device controller. It holds two 8-bit registers on a small indexed register bus. One is an enable register and one is a sticky flag register. Single-cycle event pulses from the line-state logic set the flags. The block raises one registered interrupt request towards the CPU whenever a set flag has its enable bit set too.

A bus reset changes the enable register by itself. Most enables drop to zero, and the bus-reset enable is forced on. The enable for bus-reset-done keeps whatever it held before. Software can reach either register only while the controller enable input is high. Flags are cleared by writing zeros. A write of ones leaves the flags untouched.

Top module: `usb_irq_pair`

## Requirements
- R1: After reset, the enable register and the flag register both read 00h and `irq_o` is low.
- R2: While `ctrl_en` is 1, the enable register at index 04h is written by a `reg_wr` strobe and returned on `reg_rdata` during a `reg_rd` strobe. A write takes effect at the clock edge.
- R3: The flag register sits at index 05h. A 1 on `evt_i[i]` sets flag bit i, and the flag stays set. Bit positions, from 7 down to 0, are: bus reset done, VBUS present, VBUS absent, suspend, bus reset, bus activity, remote wake-up done, D+ activity. Enable bit i gates flag bit i.
- R4: Writing index 05h clears every flag bit written as 0 and leaves every flag bit written as 1 unchanged.
- R5: When an event and a software clear hit the same flag bit in one cycle, the flag ends up set.
- R6: A bus reset event (`evt_i[3]`) clears enable bits 6, 5, 4, 2, 1 and 0, and sets enable bit 3. This holds even when software writes the enable register in the same cycle.
- R7: Enable bit 7 is not changed by a bus reset. It keeps its old value. If a write to 04h happens in the same cycle as the bus reset, bit 7 takes the written value.
- R8: While `ctrl_en` is 0, writes to either register are ignored and `reg_rdata` is 00h. A read with no `reg_rd` strobe also returns 00h.
- R9: `irq_o` is registered. At each clock edge it takes the value of `ctrl_en` AND (any bit of flags AND enables), computed from the values before that edge. It therefore follows a flag, enable or `ctrl_en` change one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_en | input | 1 | USB controller enable; gates register access and the request |
| reg_addr | input | 5 | Register index |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| evt_i | input | 8 | Event pulses, one bit per flag position |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
Two collisions are provoked on purpose. In the first, the bench drives a flag-clearing write and an event for the same bit on one clock edge, and the flag must read back as set. In the second, a write to the enable register coincides with a bus reset pulse. The read-back must show bits 6..4 and 2..0 cleared, bit 3 set, and bit 7 equal to the written value. The request latency is judged by sampling `irq_o` at the falling edge right after an enable write, where it must still be low, and again one cycle later.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;

    localparam int DW = 8;
    localparam int AW = 5;

    localparam logic [AW-1:0] ENA_INDEX = 5'h04;
    localparam logic [AW-1:0] FLG_INDEX = 5'h05;

    // bit positions the bus-reset logic depends on
    localparam int BRST_POS   = 3;
    localparam int BRSTDN_POS = 7;

    localparam logic [DW-1:0] FORCE_MASK = DW'(1) << BRST_POS;
    localparam logic [DW-1:0] HOLD_MASK  = DW'(1) << BRSTDN_POS;

    typedef struct packed {
        logic [DW-1:0] en;
        logic [DW-1:0] flg;
        logic          req;
    } irq_state_t;

endpackage

// File: rtl/usb_irq_decode.sv
module usb_irq_decode #(
    parameter int              AW      = usb_irq_pkg::AW,
    parameter logic [AW-1:0]   ENA_IDX = usb_irq_pkg::ENA_INDEX,
    parameter logic [AW-1:0]   FLG_IDX = usb_irq_pkg::FLG_INDEX
) (
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic          rd,
    input  logic          ctrl_en,
    output logic          en_wr,
    output logic          flg_wr,
    output logic          en_rd,
    output logic          flg_rd
);
    logic hit_en;
    logic hit_flg;

    assign hit_en  = (addr == ENA_IDX);
    assign hit_flg = (addr == FLG_IDX);

    assign en_wr  = ctrl_en & wr & hit_en;
    assign flg_wr = ctrl_en & wr & hit_flg;
    assign en_rd  = ctrl_en & rd & hit_en;
    assign flg_rd = ctrl_en & rd & hit_flg;
endmodule

// File: rtl/usb_irq_en_next.sv
module usb_irq_en_next #(
    parameter int            DW    = usb_irq_pkg::DW,
    parameter logic [DW-1:0] HOLD  = usb_irq_pkg::HOLD_MASK,
    parameter logic [DW-1:0] FORCE = usb_irq_pkg::FORCE_MASK
) (
    input  logic [DW-1:0] cur,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          brst,
    output logic [DW-1:0] nx
);
    always_comb begin
        nx = wr ? wdata : cur;
        // the bus reset overrides a write on every bit except the held ones
        if (brst) begin
            nx = (nx & HOLD) | FORCE;
        end
    end
endmodule

// File: rtl/usb_irq_flg_next.sv
module usb_irq_flg_next #(
    parameter int DW = usb_irq_pkg::DW
) (
    input  logic [DW-1:0] cur,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] evt,
    output logic [DW-1:0] nx
);
    for (genvar i = 0; i < DW; i++) begin : g_bit
        logic clr;
        assign clr   = wr & ~wdata[i];
        assign nx[i] = evt[i] | (cur[i] & ~clr);   // event beats clear
    end
endmodule

// File: rtl/usb_irq_pair.sv
module usb_irq_pair
    import usb_irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_en,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic [DW-1:0] evt_i,
    output logic          irq_o
);
    irq_state_t state_d;
    irq_state_t state_q;

    logic          en_wr;
    logic          flg_wr;
    logic          en_rd;
    logic          flg_rd;
    logic [DW-1:0] en_nx;
    logic [DW-1:0] flg_nx;

    usb_irq_decode #(
        .AW      (AW),
        .ENA_IDX (ENA_INDEX),
        .FLG_IDX (FLG_INDEX)
    ) u_decode (
        .addr    (reg_addr),
        .wr      (reg_wr),
        .rd      (reg_rd),
        .ctrl_en (ctrl_en),
        .en_wr   (en_wr),
        .flg_wr  (flg_wr),
        .en_rd   (en_rd),
        .flg_rd  (flg_rd)
    );

    usb_irq_en_next #(
        .DW    (DW),
        .HOLD  (HOLD_MASK),
        .FORCE (FORCE_MASK)
    ) u_en_next (
        .cur   (state_q.en),
        .wr    (en_wr),
        .wdata (reg_wdata),
        .brst  (evt_i[BRST_POS]),
        .nx    (en_nx)
    );

    usb_irq_flg_next #(
        .DW (DW)
    ) u_flg_next (
        .cur   (state_q.flg),
        .wr    (flg_wr),
        .wdata (reg_wdata),
        .evt   (evt_i),
        .nx    (flg_nx)
    );

    always_comb begin
        state_d     = state_q;
        state_d.en  = en_nx;
        state_d.flg = flg_nx;
        state_d.req = ctrl_en & (|(state_q.en & state_q.flg));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (en_rd) begin
            reg_rdata = state_q.en;
        end else if (flg_rd) begin
            reg_rdata = state_q.flg;
        end
    end

    assign irq_o = state_q.req;
endmodule

// File: rtl/usb_irq_checker.sv
module usb_irq_checker
    import usb_irq_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          ctrl_en,
    input logic [AW-1:0] reg_addr,
    input logic          reg_wr,
    input logic [DW-1:0] reg_wdata,
    input logic [DW-1:0] reg_rdata,
    input logic [DW-1:0] evt_i,
    input logic          irq_o,
    input logic [DW-1:0] en_q,
    input logic [DW-1:0] flg_q
);
    logic          sw_en_wr;
    logic [DW-1:0] sw_clr;

    assign sw_en_wr = ctrl_en && reg_wr && (reg_addr == ENA_INDEX);
    assign sw_clr   = (ctrl_en && reg_wr && (reg_addr == FLG_INDEX)) ? ~reg_wdata : '0;

    assert_irq_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == $past(ctrl_en && (|(en_q & flg_q))));

    assert_brst_enables_R6: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i[BRST_POS] |=> ((en_q & ~HOLD_MASK) == FORCE_MASK));

    assert_brstdn_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i[BRST_POS] && !sw_en_wr) |=> (en_q[BRSTDN_POS] == $past(en_q[BRSTDN_POS])));

    assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(flg_q) & ~$past(sw_clr)) & ~flg_q) == '0);

    assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(evt_i) & ~flg_q) == '0);

    assert_locked_regs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && (evt_i == '0)) |=> ($stable(en_q) && $stable(flg_q)));

    assert_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |-> (reg_rdata == '0));
endmodule

bind usb_irq_pair usb_irq_checker u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_en   (ctrl_en),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .evt_i     (evt_i),
    .irq_o     (irq_o),
    .en_q      (state_q.en),
    .flg_q     (state_q.flg)
);

// File: tb/usb_irq_pair_bench.sv
module usb_irq_pair_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_en = 1'b0;
    logic [4:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] evt_i = '0;
    logic       irq_o;

    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    usb_irq_pair u_usb_irq_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_en   (ctrl_en),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt_i     (evt_i),
        .irq_o     (irq_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // write with optional event pulse on the same edge
    task automatic wr_evt(input logic [4:0] a, input logic [7:0] d, input logic [7:0] ev);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1; evt_i = ev;
        @(negedge clk);
        reg_wr = 1'b0; evt_i = '0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        wr_evt(a, d, 8'h00);
    endtask

    task automatic pulse(input logic [7:0] ev);
        @(negedge clk);
        evt_i = ev;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] v);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        reg_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(5'h04, v); check("R1 enable", v, 8'h00);
        rd(5'h05, v); check("R1 flags", v, 8'h00);
        check("R1 irq", {7'd0, irq_o}, 8'h00);
    endtask

    task automatic t_enable_rw();
        logic [7:0] v;
        wr(5'h04, 8'hA5); rd(5'h04, v); check("R2 enable A5", v, 8'hA5);
        wr(5'h04, 8'h52); rd(5'h04, v); check("R2 enable 52", v, 8'h52);
        reg_addr = 5'h04; #1 check("R8 no rd strobe", reg_rdata, 8'h00);
        wr(5'h04, 8'h00);
    endtask

    task automatic t_flags();
        logic [7:0] v;
        pulse(8'h81); rd(5'h05, v); check("R3 set 81", v, 8'h81);
        pulse(8'h24); rd(5'h05, v); check("R3 sticky A5", v, 8'hA5);
        wr(5'h05, 8'h7F); rd(5'h05, v); check("R4 clear bit7", v, 8'h25);
        wr(5'h05, 8'h00); rd(5'h05, v); check("R4 clear all", v, 8'h00);
    endtask

    task automatic t_event_vs_clear();
        logic [7:0] v;
        pulse(8'h12);
        wr_evt(5'h05, 8'h00, 8'h02); rd(5'h05, v); check("R5 event wins", v, 8'h02);
        wr(5'h05, 8'h00);
    endtask

    task automatic t_bus_reset();
        logic [7:0] v;
        wr(5'h04, 8'h77); pulse(8'h08); rd(5'h04, v); check("R6 brst 77", v, 8'h08);
        wr(5'h04, 8'hF7); pulse(8'h08); rd(5'h04, v); check("R7 bit7 held", v, 8'h88);
        wr_evt(5'h04, 8'h7F, 8'h08); rd(5'h04, v); check("R6 brst beats write", v, 8'h08);
        wr_evt(5'h04, 8'h80, 8'h08); rd(5'h04, v); check("R7 bit7 written", v, 8'h88);
        wr(5'h05, 8'h00); wr(5'h04, 8'h00);
    endtask

    task automatic t_disabled();
        logic [7:0] v;
        wr(5'h04, 8'h81); pulse(8'h01);
        @(negedge clk); ctrl_en = 1'b0;
        wr(5'h04, 8'h00); wr(5'h05, 8'h00);
        rd(5'h04, v); check("R8 read zero en", v, 8'h00);
        rd(5'h05, v); check("R8 read zero flg", v, 8'h00);
        ctrl_en = 1'b1;
        rd(5'h04, v); check("R8 enable kept", v, 8'h81);
        rd(5'h05, v); check("R8 flags kept", v, 8'h01);
        wr(5'h05, 8'h00); wr(5'h04, 8'h00);
    endtask

    task automatic t_irq();
        pulse(8'h04);
        @(negedge clk); check("R9 masked", {7'd0, irq_o}, 8'h00);
        wr(5'h04, 8'h04);
        check("R9 one clock lag", {7'd0, irq_o}, 8'h00);
        @(negedge clk); check("R9 raised", {7'd0, irq_o}, 8'h01);
        ctrl_en = 1'b0;
        @(negedge clk); check("R9 gated by ctrl_en", {7'd0, irq_o}, 8'h00);
        ctrl_en = 1'b1;
        @(negedge clk); check("R9 re-raised", {7'd0, irq_o}, 8'h01);
        wr(5'h05, 8'hFB);
        check("R9 still high", {7'd0, irq_o}, 8'h01);
        @(negedge clk); check("R9 dropped", {7'd0, irq_o}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1; ctrl_en = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable_rw();
        t_flags();
        t_event_vs_clear();
        t_bus_reset();
        t_disabled();
        t_irq();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule